// File: doc/BRIEF.md
# Dual Four-Bit Addressable Latch Bank

This block keeps two banks of four storage bits and shows all eight on parallel outputs. Both banks share one 2-bit bit-select, an active-low enable and an active-low clear. Each bank has its own serial data bit. The enable and clear pair picks one of four modes:

- **Wipe:** every bit is zeroed.
- **Steer:** each bank acts as a 1-to-4 demultiplexer. The selected bit takes the bank's data bit and the other three are forced low.
- **Write:** only the selected bit of each bank takes its data bit.
- **Hold:** every stored bit is kept.

A typical use is serial-to-parallel loading, where one bit is placed at a time into a status or control word.

The block is a clocked register. Every mode decision is sampled on the rising clock edge, and the outputs show the result one cycle after the inputs are applied, so no transparent latches are inferred. A synchronous active-high reset zeroes all bits.

Top module: `dual_addr_latch`

## Requirements
- R1: While `rst` is high at a rising edge, all eight outputs are 0 after that edge, whatever `en_n`, `clr_n` and the data inputs are.
- R2: With `en_n`=1 and `clr_n`=0 at a rising edge, all eight outputs are 0 after that edge.
- R3: With `en_n`=0 and `clr_n`=0 at a rising edge, after that edge each bank's selected bit equals that bank's data input and its other three bits are 0.
- R4: With `en_n`=0 and `clr_n`=1 at a rising edge, after that edge each bank's selected bit equals that bank's data input and its other three bits are unchanged.
- R5: With `en_n`=1 and `clr_n`=1 at a rising edge, all eight outputs keep their values.
- R6: Select value k on `sel` (bit 0 is the least significant) chooses output bit k, that is `q_a[k]` and `q_b[k]`, for k from 0 to 3, the same way in both banks.
- R7: Bank A is written only from `din_a` and bank B only from `din_b`. A value on one data input never appears in the other bank.
- R8: `sel` must not change between two consecutive write-mode cycles. It may change only when the current or the previous cycle is in another mode, and a checker flags any breach.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| sel | input | 2 | Shared bit select; bit 0 is the LSB |
| en_n | input | 1 | Active-low enable |
| clr_n | input | 1 | Active-low clear |
| din_a | input | 1 | Data bit for bank A |
| din_b | input | 1 | Data bit for bank B |
| q_a | output | 4 | Stored bits of bank A |
| q_b | output | 4 | Stored bits of bank B |

## Verification
The hardest case to reach is a write-mode cycle whose neighbouring bits hold a mixed pattern left by earlier writes. Only then does an update that wrongly disturbs the unselected bits show at the outputs, instead of rewriting zeros over zeros. To reach it, the stimulus fills each bank with ones and zeros, chosen independently per bank, through write cycles separated by hold cycles. A long random run then mixes all four modes so that steer and wipe cycles land on well-filled banks. The random run moves the select only where R8 allows it, so the two banks stay distinguishable and their contents stay rich.

// File: rtl/dual_addr_latch.sv
module dual_addr_latch #(
  parameter int BITS = 4,
  localparam int SW = (BITS > 1) ? $clog2(BITS) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [SW-1:0]   sel,
  input  logic            en_n,
  input  logic            clr_n,
  input  logic            din_a,
  input  logic            din_b,
  output logic [BITS-1:0] q_a,
  output logic [BITS-1:0] q_b
);

  logic            m_wipe, m_steer, m_write;
  logic [BITS-1:0] onehot;
  logic [BITS-1:0] nxt_a, nxt_b;

  assign m_wipe  =  en_n & ~clr_n;
  assign m_steer = ~en_n & ~clr_n;
  assign m_write = ~en_n &  clr_n;
  assign onehot  = BITS'(1) << sel;

  assign nxt_a = m_wipe  ? '0 :
                 m_steer ? (onehot & {BITS{din_a}}) :
                 m_write ? ((q_a & ~onehot) | (onehot & {BITS{din_a}})) :
                           q_a;

  assign nxt_b = m_wipe  ? '0 :
                 m_steer ? (onehot & {BITS{din_b}}) :
                 m_write ? ((q_b & ~onehot) | (onehot & {BITS{din_b}})) :
                           q_b;

  always_ff @(posedge clk) begin
    if (rst) begin
      q_a <= '0;
      q_b <= '0;
    end else begin
      q_a <= nxt_a;
      q_b <= nxt_b;
    end
  end

  // R1
  reset_zero_chk: assert property (@(posedge clk)
    rst |=> (q_a == '0 && q_b == '0));

  // R2
  wipe_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (en_n && !clr_n) |=> (q_a == '0 && q_b == '0));

  // R3
  steer_single_chk: assert property (@(posedge clk) disable iff (rst)
    (!en_n && !clr_n) |=> ($countones(q_a) <= 1 && $countones(q_b) <= 1 &&
                           q_a[$past(sel)] == $past(din_a) &&
                           q_b[$past(sel)] == $past(din_b)));

  // R4
  write_bit_chk: assert property (@(posedge clk) disable iff (rst)
    (!en_n && clr_n) |=> (q_a[$past(sel)] == $past(din_a) &&
                          q_b[$past(sel)] == $past(din_b)));

  // R5
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (en_n && clr_n) |=> ($stable(q_a) && $stable(q_b)));

  // R8
  sel_steady_chk: assert property (@(posedge clk) disable iff (rst)
    (!en_n && clr_n && $past(!en_n && clr_n)) |-> $stable(sel));

endmodule

// File: tb/dual_addr_latch_bench.sv
`timescale 1ns/1ps
module dual_addr_latch_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] sel = 2'd0;
  logic       en_n = 1'b1;
  logic       clr_n = 1'b1;
  logic       din_a = 1'b0;
  logic       din_b = 1'b0;
  logic [3:0] q_a, q_b;

  int checks = 0;
  int failures = 0;
  bit ma [4];
  bit mb [4];

  always #2.5 clk = ~clk;

  dual_addr_latch u_dual_addr_latch (
    .clk(clk), .rst(rst), .sel(sel), .en_n(en_n), .clr_n(clr_n),
    .din_a(din_a), .din_b(din_b), .q_a(q_a), .q_b(q_b)
  );

  function automatic logic [3:0] pack(input bit m [4]);
    logic [3:0] v;
    for (int i = 0; i < 4; i++) v[i] = m[i];
    return v;
  endfunction

  task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  // Drives one cycle from a falling edge, updates the model at the rising
  // edge and compares both banks at the next falling edge.
  task automatic step(input bit r, input bit e, input bit c, input int s,
                      input bit da, input bit db, input string tag);
    rst = r; en_n = e; clr_n = c; sel = 2'(s); din_a = da; din_b = db;
    @(posedge clk);
    if (r) begin
      for (int i = 0; i < 4; i++) begin ma[i] = 0; mb[i] = 0; end
    end else if (e && !c) begin
      for (int i = 0; i < 4; i++) begin ma[i] = 0; mb[i] = 0; end
    end else if (!e && !c) begin
      for (int i = 0; i < 4; i++) begin
        ma[i] = (i == s) ? da : 1'b0;
        mb[i] = (i == s) ? db : 1'b0;
      end
    end else if (!e && c) begin
      ma[s] = da;
      mb[s] = db;
    end
    @(negedge clk);
    chk({tag, " bank A"}, q_a, pack(ma));
    chk({tag, " bank B"}, q_b, pack(mb));
  endtask

  initial begin
    #200000;
    failures++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    bit prev_w = 0;
    int cur_sel = 0;
    @(negedge clk);
    // R1: reset wins over a write-mode request with data high
    step(1, 0, 1, 2, 1, 1, "R1 reset");
    step(1, 0, 1, 3, 1, 1, "R1 reset");
    // R6 R7: place a one per address in bank A only, select moved in hold
    for (int k = 0; k < 4; k++) begin
      step(0, 1, 1, k, 0, 0, "R5 hold");
      step(0, 0, 1, k, 1, 0, "R6 R7 write select");
    end
    // R4: clear bits 1 and 3 of A, set bits 0 and 2 of B, neighbours kept
    step(0, 1, 1, 1, 0, 0, "R5 hold");
    step(0, 0, 1, 1, 0, 0, "R4 write");
    step(0, 1, 1, 3, 0, 0, "R5 hold");
    step(0, 0, 1, 3, 0, 0, "R4 write");
    step(0, 1, 1, 0, 0, 0, "R5 hold");
    step(0, 0, 1, 0, 1, 1, "R4 write");
    step(0, 1, 1, 2, 0, 0, "R5 hold");
    step(0, 0, 1, 2, 1, 1, "R4 write");
    // R8: a long write run at a fixed select touches only that bit
    step(0, 0, 1, 2, 0, 1, "R8 steady select");
    step(0, 0, 1, 2, 1, 0, "R8 steady select");
    // R3: steer zeroes the neighbours in both banks
    step(0, 0, 0, 1, 1, 0, "R3 steer");
    step(0, 0, 0, 3, 0, 1, "R3 steer");
    // R2: wipe
    step(0, 1, 1, 3, 1, 1, "R5 hold");
    step(0, 0, 1, 3, 1, 1, "R4 write");
    step(0, 1, 0, 0, 1, 1, "R2 wipe");
    // R1 mid-run, with clear inactive and hold requested
    step(0, 0, 0, 2, 1, 1, "R3 steer");
    step(1, 1, 1, 2, 1, 1, "R1 reset");
    prev_w = 0;
    for (int n = 0; n < 3000; n++) begin
      int mode = $urandom_range(0, 9);
      bit e, c;
      string tag;
      if (mode < 1)      begin e = 1; c = 0; tag = "R2 wipe";  end
      else if (mode < 3) begin e = 0; c = 0; tag = "R3 steer"; end
      else if (mode < 7) begin e = 0; c = 1; tag = "R4 write"; end
      else               begin e = 1; c = 1; tag = "R5 hold";  end
      if (!(prev_w && !e && c)) cur_sel = $urandom_range(0, 3);
      step(0, e, c, cur_sel, 1'($urandom), 1'($urandom), tag);
      prev_w = !e && c;
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule